// File: doc/BRIEF.md
# Light-Level Window Alarm with Persistence Filter

This block watches the stream of results from a light-measurement converter and raises an alarm when the light level has stayed out of a programmed window for a chosen number of conversions in a row. Each result arrives with a one-cycle strobe. The block compares it against a 16-bit floor and a 16-bit ceiling and counts the out-of-window results that come in an unbroken run. When the run reaches the selected length, the block sets a sticky status bit. It also asserts the enable of an active-low open-drain alarm pad. Status and pad enable stay set until the register interface pulses a clear. That pulse is produced when software finishes reading the control register. Conversions continue while the alarm is set, and the run counter keeps tracking them.

The alarm is held by a two-state machine. In `LT_IDLE` the alarm is quiet. The transition `hit` (a strobed result that completes the run) moves it to `LT_FIRED`. In `LT_FIRED` the status bit and the pad enable are driven high. The transition `release` (a clear pulse in a cycle with no `hit`) returns it to `LT_IDLE`. When `hit` and the clear pulse land in the same cycle, the machine stays in `LT_FIRED`. The run counter saturates at the selected length, so after a clear, a further out-of-window result fires the alarm again at once.

Top module: `lux_window_irq`

## Requirements
- R1: A strobed result is out of window when it is less than or equal to `thr_low` or greater than or equal to `thr_high`. A result strictly between the two is in window and never sets the alarm.
- R2: `persist_sel` chooses the run length: 2'b00 needs 1, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive out-of-window results before the alarm fires.
- R3: An in-window strobed result empties the run, so the full run length must build up again from zero.
- R4: On the clock edge that samples the strobe of the result completing the run, `irq_status` and `irq_pull_en` go to 1. Both stay at 1 while no clear pulse arrives, even when later results are in window.
- R5: A `status_clear` pulse in a cycle without a completing result drops `irq_status` and `irq_pull_en` to 0 at that clock edge.
- R6: When a completing result and `status_clear` coincide, the alarm stays asserted.
- R7: The run counter saturates at the selected length. After a clear, the next out-of-window result refires the alarm, whatever the selected length.
- R8: A change of `persist_sel` empties the run. A result strobed in the cycle of the change neither counts nor fires.
- R9: `conv_data` has no effect in cycles where `conv_done` is 0.
- R10: While `rst_n` is low, `irq_status` and `irq_pull_en` are 0, the run is empty and the registered persistence select is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe marking a new conversion result |
| conv_data | input | 16 | Conversion result, valid with `conv_done` |
| thr_low | input | 16 | Window floor (inclusive alarm side) |
| thr_high | input | 16 | Window ceiling (inclusive alarm side) |
| persist_sel | input | 2 | Run-length select, encoded as in R2 |
| status_clear | input | 1 | One-cycle clear pulse from the register interface |
| irq_status | output | 1 | Sticky alarm status bit |
| irq_pull_en | output | 1 | 1 = pull the active-low alarm pad low |

## Verification
Every result of this block is due on the same clock edge that samples its cause. The status bit and the pad enable change at the edge that takes in a completing strobe, or at the edge that takes in a clear pulse, and at no other edge. The bench drives each stimulus on a falling edge and holds it across one rising edge. It then reads the outputs on the next falling edge, exactly one register stage later. Run-length checks read the outputs after every result in the run, so an alarm that fires one result early or late is caught.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

    typedef enum logic [0:0] {
        LT_IDLE  = 1'b0,
        LT_FIRED = 1'b1
    } latch_state_t;

    typedef enum logic [1:0] {
        PS_LEN_A = 2'b00,
        PS_LEN_B = 2'b01,
        PS_LEN_C = 2'b10,
        PS_LEN_D = 2'b11
    } persist_code_t;

endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [DATA_W-1:0] floor_lvl,
    input  logic [DATA_W-1:0] ceil_lvl,
    output logic              outside
);
    logic at_or_below;
    logic at_or_above;

    always_comb begin
        at_or_below = (sample <= floor_lvl);
        at_or_above = (sample >= ceil_lvl);
        outside     = at_or_below | at_or_above;
    end
endmodule

// File: rtl/lwi_run_counter.sv
module lwi_run_counter
    import lwi_pkg::*;
#(
    parameter int LEN_A = 1,
    parameter int LEN_B = 4,
    parameter int LEN_C = 8,
    parameter int LEN_D = 16,
    parameter int CNT_W = $clog2(LEN_D + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       outside,
    input  logic [1:0] sel,
    output logic       hit
);
    logic [1:0]       sel_q;
    logic             sel_chg;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] target;
    logic [CNT_W:0]   run_plus;

    always_comb begin
        unique case (persist_code_t'(sel_q))
            PS_LEN_A: target = CNT_W'(LEN_A);
            PS_LEN_B: target = CNT_W'(LEN_B);
            PS_LEN_C: target = CNT_W'(LEN_C);
            PS_LEN_D: target = CNT_W'(LEN_D);
            default:  target = CNT_W'(LEN_A);
        endcase
    end

    always_comb begin
        sel_chg  = (sel != sel_q);
        run_plus = {1'b0, run_q} + (CNT_W+1)'(1);
        hit      = strobe && outside && !sel_chg && (run_plus >= {1'b0, target});
    end

    always_comb begin
        run_d = run_q;
        if (sel_chg) begin
            run_d = '0;
        end else if (strobe) begin
            if (!outside) begin
                run_d = '0;
            end else if (run_plus >= {1'b0, target}) begin
                run_d = target;
            end else begin
                run_d = run_plus[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
            run_q <= '0;
        end else begin
            sel_q <= sel;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/lwi_alarm_fsm.sv
module lwi_alarm_fsm
    import lwi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear,
    output logic status,
    output logic pull_en
);
    latch_state_t state_q;
    latch_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LT_IDLE:  if (hit) state_d = LT_FIRED;
            LT_FIRED: if (clear && !hit) state_d = LT_IDLE;
            default:  state_d = LT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        status  = 1'b0;
        pull_en = 1'b0;
        unique case (state_q)
            LT_IDLE: begin
                status  = 1'b0;
                pull_en = 1'b0;
            end
            LT_FIRED: begin
                status  = 1'b1;
                pull_en = 1'b1;
            end
            default: begin
                status  = 1'b0;
                pull_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq #(
    parameter int DATA_W = 16,
    parameter int LEN_A  = 1,
    parameter int LEN_B  = 4,
    parameter int LEN_C  = 8,
    parameter int LEN_D  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [DATA_W-1:0] thr_low,
    input  logic [DATA_W-1:0] thr_high,
    input  logic [1:0]        persist_sel,
    input  logic              status_clear,
    output logic              irq_status,
    output logic              irq_pull_en
);
    localparam int CNT_W = $clog2(LEN_D + 1);

    logic outside;
    logic hit;

    lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .sample    (conv_data),
        .floor_lvl (thr_low),
        .ceil_lvl  (thr_high),
        .outside   (outside)
    );

    lwi_run_counter #(
        .LEN_A (LEN_A),
        .LEN_B (LEN_B),
        .LEN_C (LEN_C),
        .LEN_D (LEN_D),
        .CNT_W (CNT_W)
    ) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (conv_done),
        .outside (outside),
        .sel     (persist_sel),
        .hit     (hit)
    );

    lwi_alarm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .clear   (status_clear),
        .status  (irq_status),
        .pull_en (irq_pull_en)
    );
endmodule

// File: rtl/lux_window_irq_chk.sv
module lux_window_irq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_data,
    input logic [DATA_W-1:0] thr_low,
    input logic [DATA_W-1:0] thr_high,
    input logic [1:0]        persist_sel,
    input logic              status_clear,
    input logic              irq_status,
    input logic              irq_pull_en
);
    AST_PAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull_en == irq_status); // R4

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status && !status_clear |=> irq_status); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status && status_clear && !conv_done |=> !irq_status); // R5

    AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_status && !conv_done |=> !irq_status); // R9

    AST_INSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_status && conv_done && conv_data > thr_low && conv_data < thr_high
        |=> !irq_status); // R1

    AST_SINGLE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && persist_sel == 2'b00 && $stable(persist_sel)
        && (conv_data <= thr_low || conv_data >= thr_high) |=> irq_status); // R2
endmodule

bind lux_window_irq lux_window_irq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_done    (conv_done),
    .conv_data    (conv_data),
    .thr_low      (thr_low),
    .thr_high     (thr_high),
    .persist_sel  (persist_sel),
    .status_clear (status_clear),
    .irq_status   (irq_status),
    .irq_pull_en  (irq_pull_en)
);

// File: tb/lux_window_irq_tb.sv
module lux_window_irq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_data = '0;
    logic [15:0] thr_low = 16'd100;
    logic [15:0] thr_high = 16'd200;
    logic [1:0]  persist_sel = 2'b00;
    logic        status_clear = 1'b0;
    logic        irq_status;
    logic        irq_pull_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lux_window_irq u_dut (
        .clk (clk), .rst_n (rst_n), .conv_done (conv_done), .conv_data (conv_data),
        .thr_low (thr_low), .thr_high (thr_high), .persist_sel (persist_sel),
        .status_clear (status_clear), .irq_status (irq_status), .irq_pull_en (irq_pull_en)
    );

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_status !== exp || irq_pull_en !== exp) begin
            errors++;
            $display("FAIL %s: status=%b pull=%b expected=%b", req, irq_status, irq_pull_en, exp);
        end
    endtask

    // drive on falling edge, one rising edge, sample on next falling edge
    task automatic conv(input logic [15:0] d, input logic clr = 1'b0);
        conv_done = 1'b1; conv_data = d; status_clear = clr;
        @(negedge clk);
        conv_done = 1'b0; status_clear = 1'b0;
    endtask

    task automatic clear_pulse();
        status_clear = 1'b1;
        @(negedge clk);
        status_clear = 1'b0;
    endtask

    task automatic set_sel(input logic [1:0] s);
        persist_sel = s;
        @(negedge clk);
    endtask

    task automatic fresh();
        clear_pulse();
        conv(16'd150);
    endtask

    task automatic t_reset();
        check("R10 reset", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after release", 1'b0);
    endtask

    task automatic t_edges();
        set_sel(2'b00);
        conv(16'd101); check("R1 just above floor", 1'b0);
        conv(16'd199); check("R1 just below ceiling", 1'b0);
        conv(16'd100); check("R1 equal floor fires", 1'b1);
        fresh();
        conv(16'd200); check("R1 equal ceiling fires", 1'b1);
        fresh();
        conv(16'd0); check("R1 zero fires", 1'b1);
        fresh();
        conv(16'hFFFF); check("R1 full scale fires", 1'b1);
        fresh();
    endtask

    task automatic t_len(input logic [1:0] s, input int n);
        set_sel(s);
        fresh();
        for (int i = 1; i < n; i++) begin
            conv(16'd250); check("R2 run short", 1'b0);
        end
        conv(16'd30); check("R2 run complete", 1'b1);
        fresh();
    endtask

    task automatic t_break();
        set_sel(2'b01);
        fresh();
        for (int i = 0; i < 3; i++) conv(16'd5);
        conv(16'd150); check("R3 inside breaks run", 1'b0);
        for (int i = 0; i < 3; i++) conv(16'd5);
        check("R3 rebuilt three", 1'b0);
        conv(16'd5); check("R3 rebuilt four", 1'b1);
        fresh();
    endtask

    task automatic t_hold_clear();
        set_sel(2'b00);
        fresh();
        conv(16'd300); check("R4 fires", 1'b1);
        conv(16'd150); check("R4 sticky through inside", 1'b1);
        repeat (5) @(negedge clk);
        check("R4 sticky idle", 1'b1);
        clear_pulse(); check("R5 clear drops", 1'b0);
    endtask

    task automatic t_collide();
        set_sel(2'b00);
        fresh();
        conv(16'd300); check("R6 armed", 1'b1);
        conv(16'd300, 1'b1); check("R6 trigger beats clear", 1'b1);
        clear_pulse(); check("R6 later clear", 1'b0);
    endtask

    task automatic t_saturate();
        set_sel(2'b11);
        fresh();
        for (int i = 0; i < 16; i++) conv(16'd400);
        check("R7 sixteen fire", 1'b1);
        clear_pulse(); check("R7 cleared", 1'b0);
        conv(16'd400); check("R7 refire next result", 1'b1);
        fresh();
    endtask

    task automatic t_sel_change();
        set_sel(2'b01);
        fresh();
        for (int i = 0; i < 3; i++) conv(16'd10);
        set_sel(2'b10);
        for (int i = 0; i < 7; i++) conv(16'd10);
        check("R8 old run discarded", 1'b0);
        conv(16'd10); check("R8 new run of eight", 1'b1);
        fresh();
        set_sel(2'b00);
        persist_sel = 2'b01; conv(16'd10);
        check("R8 change-cycle strobe ignored", 1'b0);
        fresh();
    endtask

    task automatic t_nostrobe();
        set_sel(2'b00);
        fresh();
        conv_data = 16'd0;
        repeat (4) @(negedge clk);
        conv_data = 16'hFFFF;
        repeat (4) @(negedge clk);
        check("R9 data without strobe", 1'b0);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        t_edges();
        t_len(2'b00, 1);
        t_len(2'b01, 4);
        t_len(2'b10, 8);
        t_len(2'b11, 16);
        t_break();
        t_hold_clear();
        t_collide();
        t_saturate();
        t_sel_change();
        t_nostrobe();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule